// File: doc/BRIEF.md
# XGMII Receive Frame Extractor

This block takes the receive side of a 10-gigabit media-independent interface, one 32-bit column of four byte lanes and four control flags per clock edge. It turns that into a 64-bit client byte stream. The column taken at the rising edge becomes the low half of an internal 64-bit pair, and the column taken at the falling edge becomes the high half. The block finds each start column and discards the preamble and delimiter. It aligns the payload so that the first payload byte always sits in output lane 0. It then strips the four trailing check bytes and, when the length/type field asks for it, the zero padding added to short frames.

Each frame ends with a single-cycle status pulse. The frame is good when a terminate character closes it. It is bad when an error character closes it, or when a stray control character cuts it short. The check bytes are removed but not verified here.

The output stream is valid-only. `o_vld` qualifies `o_data` and `o_keep`, and there is no ready input. The line side cannot be paused, so back-pressure is not possible and the consumer must accept every beat in the cycle it appears. The status pins are plain single-cycle strobes.

Top module: `xgmii_rx_unpacker`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, `o_keep` is 8'h00 and both `o_good` and `o_bad` are 0.
- R2: A frame begins at a column whose lane 0 holds 0xFB with control flags 4'b0001, on either clock edge. That column and the next one (the delimiter column, 0xD5 in lane 3) are never presented.
- R3: Payload bytes leave in arrival order. Byte n of a frame's payload goes out in lane n mod 8 (bits 8i+7..8i) of beat n div 8. `o_keep` is always a run of ones starting at lane 0.
- R4: The four bytes just before the closing control character are never presented. Every byte before them is presented, except as stated in R5.
- R5: Let v be payload bytes 12 and 13 read high byte first. If v is below 0x0600 and 14+v is less than the number of bytes received before the check bytes, only the first 14+v bytes are presented.
- R6: No bytes are trimmed when v is 0x0600 or more, when 14+v is not below the received count, or when the payload is shorter than 14 bytes.
- R7: A frame closed by 0xFD in the first control lane raises `o_good` for exactly one cycle.
- R8: A frame closed by 0xFE raises `o_bad` for exactly one cycle and never `o_good`.
- R9: Any other control character inside the payload, including a new 0xFB, makes the frame bad. The receiver then hunts for a start column again, and the next well-formed frame is received intact.
- R10: For each frame exactly one flag pulses. It comes after the frame's last beat and before the next frame's first beat, and `o_keep` is zero in that cycle.
- R11: `o_keep` is zero while only idle columns (0x07 in every lane, all control flags set) arrive.
- R12: `o_vld` is high exactly when `o_keep` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; columns are taken on both edges |
| rst | input | 1 | Synchronous reset, active high |
| xd_in | input | 32 | Column data, lane i in bits 8i+7..8i |
| xc_in | input | 4 | Column control flags, bit i marks lane i as control |
| o_vld | output | 1 | Beat qualifier |
| o_data | output | 64 | Client bytes, lane i in bits 8i+7..8i |
| o_keep | output | 8 | Per-lane byte valid mask |
| o_good | output | 1 | One-cycle pulse: frame closed normally |
| o_bad | output | 1 | One-cycle pulse: frame errored or aborted |

## Verification
The hardest cases to reach are the ones where the frame end falls at an awkward place in the 64-bit pairing. The start column can land on the rising or the falling edge. The terminate character can sit in any of the eight aligned lanes, which pushes the check bytes across a beat boundary or leaves a remainder beat after the held word. The stimulus puts a random number of idle columns between frames so that both start phases occur. Payload lengths are drawn widely, and directed frames are added at the exact trim boundaries (14+v one below, at, and above the received count), with runts, error-closed frames and payloads cut by an injected control character.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_ERR   = 8'hFE;
  localparam int unsigned HDR_BYTES = 14;
  localparam logic [15:0] TYPE_FLOOR = 16'h0600;

  // 64-bit pair of byte lanes with one control flag per lane
  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  c;
  } word_t;

  typedef enum logic [1:0] {ST_HUNT, ST_BODY, ST_TAIL} rx_state_t;

  // lanes whose absolute byte index (base + lane) falls below lim
  function automatic logic [7:0] keep_below(input int unsigned base, input int unsigned lim);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = ((base + 32'(i)) < lim);
    return r;
  endfunction

endpackage

// File: rtl/rxu_ddr_cap.sv
module rxu_ddr_cap
  import rxu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] xd_in,
  input  logic [3:0]  xc_in,
  output word_t       pair
);
  logic [31:0] lo_d, hi_d;
  logic [3:0]  lo_c, hi_c;

  // second column of a pair arrives on the falling edge
  always_ff @(negedge clk) begin
    if (rst) begin
      hi_d <= '0;
      hi_c <= '0;
    end else begin
      hi_d <= xd_in;
      hi_c <= xc_in;
    end
  end

  // first column on the rising edge; the previous pair is completed here
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_d <= '0;
      lo_c <= '0;
      pair <= '0;
    end else begin
      lo_d   <= xd_in;
      lo_c   <= xc_in;
      pair.d <= {hi_d, lo_d};
      pair.c <= {hi_c, lo_c};
    end
  end
endmodule

// File: rtl/rxu_align.sv
module rxu_align
  import rxu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  word_t pair,
  output word_t w0,
  output word_t w4
);
  logic [31:0] prev_d;
  logic [3:0]  prev_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_d <= '0;
      prev_c <= '0;
    end else begin
      prev_d <= pair.d[63:32];
      prev_c <= pair.c[7:4];
    end
  end

  // w0: pair as received; w4: shifted by one column (older high half first)
  assign w0   = pair;
  assign w4.d = {pair.d[31:0], prev_d};
  assign w4.c = {pair.c[3:0], prev_c};
endmodule

// File: rtl/rxu_engine.sv
module rxu_engine
  import rxu_pkg::*;
#(
  parameter int CW = 16
)(
  input  logic        clk,
  input  logic        rst,
  input  word_t       w0,
  input  word_t       w4,
  output logic [63:0] o_data,
  output logic [7:0]  o_keep,
  output logic        o_good,
  output logic        o_bad
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  rx_state_t   st;
  logic        sel;
  logic [63:0] held;
  logic        held_v;
  logic [CW-1:0] nbytes;
  logic [CW-1:0] lim;
  logic        pend_g, pend_b;
  logic [63:0] tail_d;
  logic [7:0]  tail_k;

  word_t       w;
  logic [2:0]  k;
  logic        anyc;
  logic [7:0]  tch;
  logic        start0, start4;
  int unsigned nb_i, lim_i, rcv, pay, eff;
  logic [15:0] fv;
  logic [63:0] beat_d;
  logic [7:0]  beat_k;
  logic        ev_term, ev_abort, flag_go;

  always_comb begin
    w = sel ? w4 : w0;
    k = 3'd0;
    for (int i = 7; i >= 0; i--) if (w.c[i]) k = 3'(i);
    anyc   = |w.c;
    tch    = w.d[{k, 3'b000} +: 8];
    start0 = (w0.c == 8'h01) && (w0.d[7:0] == CH_START);
    start4 = (w4.c == 8'h01) && (w4.d[7:0] == CH_START);
    nb_i   = 32'(nbytes);
    lim_i  = 32'(lim);
    rcv    = nb_i + 32'(k);
    pay    = (rcv >= 4) ? rcv - 4 : 0;
    eff    = (lim_i < pay) ? lim_i : pay;
    fv     = {w.d[39:32], w.d[47:40]};
    beat_d   = held;
    beat_k   = '0;
    ev_term  = 1'b0;
    ev_abort = 1'b0;
    case (st)
      ST_BODY: begin
        if (!anyc) begin
          if (held_v) beat_k = keep_below(nb_i - 8, lim_i);
        end else if (tch == CH_TERM || tch == CH_ERR) begin
          ev_term = 1'b1;
          if (held_v) beat_k = keep_below(nb_i - 8, eff);
        end else begin
          ev_abort = 1'b1;
        end
      end
      ST_TAIL: begin
        beat_d = tail_d;
        beat_k = tail_k;
      end
      default: ;
    endcase
    flag_go = (beat_k == 8'h00) && (pend_g || pend_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_HUNT;
      sel    <= 1'b0;
      held   <= '0;
      held_v <= 1'b0;
      nbytes <= '0;
      lim    <= CNT_MAX;
      pend_g <= 1'b0;
      pend_b <= 1'b0;
      tail_d <= '0;
      tail_k <= '0;
      o_data <= '0;
      o_keep <= '0;
      o_good <= 1'b0;
      o_bad  <= 1'b0;
    end else begin
      o_data <= beat_d;
      o_keep <= beat_k;
      o_good <= flag_go && pend_g;
      o_bad  <= flag_go && pend_b;
      if (flag_go) begin
        pend_g <= 1'b0;
        pend_b <= 1'b0;
      end
      case (st)
        ST_BODY: begin
          if (!anyc) begin
            held   <= w.d;
            held_v <= 1'b1;
            if (nbytes <= CNT_MAX - CW'(8)) nbytes <= nbytes + CW'(8);
            if (nbytes == CW'(8) && fv < TYPE_FLOOR)
              lim <= CW'(32'(fv) + HDR_BYTES);
          end else if (ev_term) begin
            pend_g <= (tch == CH_TERM);
            pend_b <= (tch == CH_ERR);
            held_v <= 1'b0;
            if (k > 3'd4) begin
              tail_d <= w.d;
              tail_k <= keep_below(nb_i, eff);
              st     <= ST_TAIL;
            end else begin
              st <= ST_HUNT;
            end
          end else begin
            pend_g <= 1'b0;
            pend_b <= 1'b1;
            held_v <= 1'b0;
            st     <= ST_HUNT;
          end
        end
        default: begin
          st <= ST_HUNT;
          if (start4 || start0) begin
            sel    <= start4;
            st     <= ST_BODY;
            held_v <= 1'b0;
            nbytes <= '0;
            lim    <= CNT_MAX;
          end
        end
      endcase
    end
  end

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst) !(o_good && o_bad));
  // R10
  flag_quiet_chk: assert property (@(posedge clk) disable iff (rst) (o_good || o_bad) |-> (o_keep == 8'h00));
  // R7
  good_pulse_chk: assert property (@(posedge clk) disable iff (rst) o_good |=> !o_good);
  // R8
  bad_pulse_chk: assert property (@(posedge clk) disable iff (rst) o_bad |=> !o_bad);
  // R3
  keep_contig_chk: assert property (@(posedge clk) disable iff (rst) ((o_keep & (o_keep + 8'd1)) == 8'h00));
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (o_keep == 8'h00 && !o_good && !o_bad));
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BODY && $past(st) == ST_BODY) |-> $stable(sel));
endmodule

// File: rtl/xgmii_rx_unpacker.sv
module xgmii_rx_unpacker
  import rxu_pkg::*;
#(
  parameter int CW = 16
)(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] xd_in,
  input  logic [3:0]  xc_in,
  output logic        o_vld,
  output logic [63:0] o_data,
  output logic [7:0]  o_keep,
  output logic        o_good,
  output logic        o_bad
);
  word_t pair, w0, w4;

  rxu_ddr_cap u_cap (
    .clk(clk), .rst(rst), .xd_in(xd_in), .xc_in(xc_in), .pair(pair)
  );

  rxu_align u_aln (
    .clk(clk), .rst(rst), .pair(pair), .w0(w0), .w4(w4)
  );

  rxu_engine #(.CW(CW)) u_eng (
    .clk(clk), .rst(rst), .w0(w0), .w4(w4),
    .o_data(o_data), .o_keep(o_keep), .o_good(o_good), .o_bad(o_bad)
  );

  assign o_vld = |o_keep;
endmodule

// File: tb/sim_xgmii_rx_unpacker.sv
module sim_xgmii_rx_unpacker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] xd = 32'h07070707;
  logic [3:0]  xc = 4'hF;
  logic        o_vld, o_good, o_bad;
  logic [63:0] o_data;
  logic [7:0]  o_keep;

  xgmii_rx_unpacker u0 (
    .clk(clk), .rst(rst), .xd_in(xd), .xc_in(xc), .o_vld(o_vld),
    .o_data(o_data), .o_keep(o_keep), .o_good(o_good), .o_bad(o_bad)
  );

  always #4 clk = ~clk;

  int nvec = 0, nbad = 0, flags_seen = 0, frames_sent = 0;
  bit go = 1'b0, vld_mis = 1'b0, keep_gap = 1'b0;
  logic [35:0] colq[$];
  logic [8:0]  bq[$];
  logic [7:0]  pl[$];
  logic [7:0]  expb[$];
  logic [7:0]  got[$];
  int          expn[$];
  bit          expg[$];
  bit          expchk[$];
  string       exptag[$];

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_cols(input int n);
    for (int i = 0; i < n; i++) colq.push_back({4'hF, 32'h07070707});
  endtask

  task automatic flush_bq();
    while (bq.size() % 4 != 0) bq.push_back({1'b1, 8'h07});
    for (int i = 0; i < bq.size(); i += 4)
      colq.push_back({bq[i+3][8], bq[i+2][8], bq[i+1][8], bq[i][8],
                      bq[i+3][7:0], bq[i+2][7:0], bq[i+1][7:0], bq[i][7:0]});
    bq.delete();
  endtask

  // expected presented length from the trim rule
  function automatic int exp_len();
    int r = pl.size();
    int v;
    if (r >= 14) begin
      v = {pl[12], pl[13]};
      if (v < 'h600 && 14 + v < r) return 14 + v;
    end
    return r;
  endfunction

  // kind 0: /T/, 1: /E/, 2: control byte injected into payload
  task automatic add_frame(input int kind, input int plen, input bit use_f,
                           input logic [15:0] f, input bit do_pad);
    int n, p;
    bit trimmed;
    pl.delete();
    for (int i = 0; i < plen; i++) pl.push_back(8'($urandom));
    if (use_f && plen >= 14) begin
      pl[12] = f[15:8];
      pl[13] = f[7:0];
    end
    if (do_pad) while (pl.size() < 60) pl.push_back(8'h00);
    n = exp_len();
    trimmed = (n != pl.size());
    bq.push_back({1'b1, 8'hFB});
    for (int i = 0; i < 6; i++) bq.push_back({1'b0, 8'h55});
    bq.push_back({1'b0, 8'hD5});
    p = (kind == 2) ? $urandom_range(0, pl.size() - 1) : -1;
    for (int i = 0; i < pl.size(); i++)
      bq.push_back((i == p) ? {1'b1, (($urandom % 2) != 0) ? 8'hFB : 8'h07} : {1'b0, pl[i]});
    for (int i = 0; i < 4; i++) bq.push_back({1'b0, 8'($urandom)});
    bq.push_back({1'b1, (kind == 1) ? 8'hFE : 8'hFD});
    flush_bq();
    idle_cols($urandom_range(1, 5));
    frames_sent++;
    expg.push_back(kind == 0);
    expchk.push_back(kind != 2);
    exptag.push_back(trimmed ? "R5" : ((use_f && plen >= 14) ? "R6" : "R4"));
    expn.push_back(kind == 2 ? 0 : n);
    if (kind != 2) for (int i = 0; i < n; i++) expb.push_back(pl[i]);
  endtask

  task automatic drive_next();
    if (colq.size() > 0) {xc, xd} = colq.pop_front();
    else begin xd = 32'h07070707; xc = 4'hF; end
  endtask

  initial begin
    wait (go);
    forever begin
      @(negedge clk); #2; drive_next();
      @(posedge clk); #2; drive_next();
    end
  end

  // output monitor
  always @(posedge clk) begin
    #1;
    if (!rst && go) begin
      int n;
      bit g, c;
      string tg;
      int mism;
      logic [7:0] e;
      if (o_vld !== (|o_keep)) vld_mis = 1'b1;
      if ((o_keep & (o_keep + 8'd1)) != 8'h00) keep_gap = 1'b1;
      for (int i = 0; i < 8; i++) if (o_keep[i]) got.push_back(o_data[8*i +: 8]);
      if (o_good || o_bad) begin
        flags_seen++;
        if (expn.size() == 0) begin
          check(1'b0, "R10", "flag with no frame pending", 1, 0);
        end else begin
          n = expn.pop_front(); g = expg.pop_front();
          c = expchk.pop_front(); tg = exptag.pop_front();
          check(o_good == g && o_bad == !g, g ? "R7" : (c ? "R8" : "R9"),
                "flag pair {good,bad}", {o_good, o_bad}, g ? 2 : 1);
          mism = 0;
          for (int i = 0; i < n; i++) begin
            e = expb.pop_front();
            if (c && (i >= got.size() || got[i] !== e)) mism++;
          end
          if (c) begin
            check(got.size() == n, tg, "presented byte count", got.size(), n);
            check(mism == 0, "R2 R3", "mismatching payload bytes", mism, 0);
          end
        end
        got.delete();
      end
    end
  end

  initial begin
    int cyc;
    void'($urandom(32'h1A2B3C4D));
    idle_cols(30);
    add_frame(0, 60, 1'b1, 16'd46, 1'b0);   // 14+v equals received count: R6
    add_frame(0, 15, 1'b1, 16'd1, 1'b1);    // padded, trimmed to 15: R5
    add_frame(0, 59, 1'b1, 16'd45, 1'b1);   // one pad byte dropped: R5
    add_frame(0, 20, 1'b1, 16'h0600, 1'b1); // type value keeps pad: R6
    add_frame(0, 64, 1'b1, 16'h05FF, 1'b0); // field beyond received: R6
    add_frame(0, 5, 1'b0, 16'h0, 1'b0);     // runt: R4
    add_frame(1, 70, 1'b1, 16'h0800, 1'b0); // /E/: R8
    add_frame(2, 80, 1'b1, 16'h0800, 1'b0); // abort: R9
    add_frame(0, 100, 1'b1, 16'h0800, 1'b0);// frame after abort: R9
    for (int i = 0; i < 40; i++) begin
      int kind = ($urandom_range(0, 9) < 7) ? 0 : $urandom_range(1, 2);
      int plen = $urandom_range(1, 130);
      bit lenmode = $urandom_range(0, 1);
      logic [15:0] f = lenmode ? 16'($urandom_range(0, 140)) : 16'($urandom_range('h600, 'hFFFF));
      add_frame(kind, plen, 1'b1, f, plen < 60 ? $urandom_range(0, 1) : 1'b0);
    end
    repeat (4) @(posedge clk);
    #1;
    check(o_keep == 8'h00 && !o_good && !o_bad, "R1", "outputs in reset", {o_keep, o_good, o_bad}, 0);
    @(posedge clk); #2; rst = 1'b0;
    @(posedge clk); #1;
    check(o_keep == 8'h00 && !o_good && !o_bad, "R1", "outputs after reset", {o_keep, o_good, o_bad}, 0);
    go = 1'b1;
    cyc = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (o_vld) cyc++;
    end
    check(cyc == 0, "R11", "beats during idle", cyc, 0);
    cyc = 0;
    while (!(colq.size() == 0 && expn.size() == 0) && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (cyc >= 150000) check(1'b0, "R10", "watchdog expired", cyc, 0);
    repeat (20) @(posedge clk);
    #1;
    check(flags_seen == frames_sent, "R10", "status pulses", flags_seen, frames_sent);
    check(!vld_mis, "R12", "o_vld disagreed with o_keep", vld_mis, 0);
    check(!keep_gap, "R3", "non-contiguous keep seen", keep_gap, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule